// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of a binary64 fused multiply-add unit that computes z + x·y. Each of the three operands is sorted into one of six classes: zero, normal, subnormal, infinity, quiet NaN or signalling NaN. Two control bits flip the sign of the product and of the addend, so one datapath serves every multiply-add, multiply-subtract and negated variant.

From those classes the block decides whether the answer is already fixed. A NaN operand, an infinite or zero product, or an infinite addend each fix it. When the answer is fixed, the block raises the bypass flag, drives the final 64-bit result and reports an invalid-operation exception where one applies. When it is not fixed, the bypass flag stays low and the arithmetic datapath takes the operands. The effective product and addend signs are presented on every cycle for the datapath's use.

All decisions are made combinationally from the inputs. A single register stage then holds them, so every output reflects the inputs sampled at the previous rising clock edge.

Top module: `fma_special_front`

## Requirements
- R1: When x and y are both normal or subnormal and z is finite, byp_valid is 0 and byp_result is 0.
- R2: prod_sign equals x[63] XOR y[63] XOR neg_prod, and add_sign equals z[63] XOR neg_add, for every input combination.
- R3: A signalling NaN (exponent all ones, mantissa nonzero, mantissa bit 51 clear) is chosen with priority z over x over y. The result is that operand with bit 51 set, and byp_invalid is 1.
- R4: When no signalling NaN is present, a quiet NaN (mantissa bit 51 set) is returned unchanged, with priority z over x over y, and byp_invalid is 0. A signalling NaN in any operand outranks a quiet NaN in any other.
- R5: Infinity times zero, in either operand order, gives byp_invalid = 1 and the result 0x7FF8000000000000.
- R6: An infinite product with an infinite z of opposite effective sign gives invalid and 0x7FF8000000000000. Otherwise an infinite product gives an infinity carrying prod_sign.
- R7: A zero product with an infinite z gives an infinity carrying add_sign.
- R8: A zero product with a zero z gives a zero. If add_sign equals prod_sign, that zero carries the shared sign. Otherwise it is negative only when rnd_mode is 2'b11 (toward minus infinity); the other encodings are 00 nearest, 01 toward zero and 10 toward plus infinity.
- R9: A zero product with a nonzero finite z (normal or subnormal) gives z's magnitude with add_sign.
- R10: A finite nonzero product with an infinite z gives an infinity carrying add_sign, with no invalid.
- R11: While rst_n is low, every output is 0. After reset, outputs follow the inputs with one cycle of latency.
- R12: A subnormal operand counts as nonzero. A subnormal times infinity is an infinite product, not invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_z | input | 64 | Addend operand |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Invert product sign |
| neg_add | input | 1 | Invert addend sign |
| rnd_mode | input | 2 | Rounding mode (11 = toward minus infinity) |
| byp_valid | output | 1 | Result is final; datapath not needed |
| byp_result | output | 64 | Final special result |
| byp_invalid | output | 1 | Invalid-operation exception |
| prod_sign | output | 1 | Effective product sign |
| add_sign | output | 1 | Effective addend sign |

## Verification
Every decision surfaces at the ports one clock after the inputs, so a wrong class decode or a wrong priority branch shows as a wrong result word, flag or sign in the very next cycle. A broken register would hold a stale answer, and that shows when two differing vectors are applied back to back. The stimulus pairs each special class with each neighbour and pits NaNs against one another for priority. It also drives zero sums under all four rounding modes, so that a swapped condition flips an observable sign or exponent at once.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;
  localparam int FP_EW = 11;
  localparam int FP_MW = 52;
  localparam int FP_W  = 1 + FP_EW + FP_MW;
  localparam int NOPS  = 3;

  localparam logic [1:0] RM_DOWN = 2'b11;

  typedef enum logic [2:0] {
    CL_ZERO, CL_NORM, CL_SUBN, CL_INF, CL_QNAN, CL_SNAN
  } fp_class_e;

  typedef struct packed {
    logic              valid;
    logic [FP_W-1:0]   res;
    logic              inv;
    logic              psign;
    logic              asign;
  } byp_t;

  function automatic logic [FP_W-1:0] make_inf(input logic s);
    return {s, {FP_EW{1'b1}}, {FP_MW{1'b0}}};
  endfunction

  function automatic logic [FP_W-1:0] make_zero(input logic s);
    return {s, {(FP_W-1){1'b0}}};
  endfunction

  function automatic logic [FP_W-1:0] default_nan();
    return {1'b0, {FP_EW{1'b1}}, 1'b1, {(FP_MW-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fma_sp_classify.sv
module fma_sp_classify
  import fma_sp_pkg::*;
#(
  parameter int EW = FP_EW,
  parameter int MW = FP_MW
) (
  input  logic [EW+MW:0] operand,
  output fp_class_e      cls
);
  logic [EW-1:0] expo;
  logic [MW-1:0] mant;

  assign expo = operand[EW+MW-1:MW];
  assign mant = operand[MW-1:0];

  always_comb begin
    if (expo == {EW{1'b1}}) begin
      if (mant == '0)          cls = CL_INF;
      else if (mant[MW-1])     cls = CL_QNAN;
      else                     cls = CL_SNAN;
    end else if (expo == '0) begin
      cls = (mant == '0) ? CL_ZERO : CL_SUBN;
    end else begin
      cls = CL_NORM;
    end
  end

  // the sign bit is not needed for classification
  logic unused_sign;
  assign unused_sign = operand[EW+MW];
endmodule

// File: rtl/fma_sp_nan_pick.sv
module fma_sp_nan_pick
  import fma_sp_pkg::*;
#(
  parameter int W  = FP_W,
  parameter int MW = FP_MW,
  parameter int N  = NOPS
) (
  input  logic [N-1:0][W-1:0] ops,
  input  fp_class_e           cls [N],
  output logic                hit,
  output logic                sig,
  output logic [W-1:0]        value
);
  logic         hit_s, hit_q;
  logic [W-1:0] val_s, val_q;

  always_comb begin
    hit_s = 1'b0;
    hit_q = 1'b0;
    val_s = '0;
    val_q = '0;
    // walk from the lowest priority up so the lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (cls[i] == CL_SNAN) begin
        hit_s = 1'b1;
        val_s = ops[i] | (W'(1) << (MW - 1));
      end
      if (cls[i] == CL_QNAN) begin
        hit_q = 1'b1;
        val_q = ops[i];
      end
    end
    hit   = hit_s | hit_q;
    sig   = hit_s;
    value = hit_s ? val_s : val_q;
  end
endmodule

// File: rtl/fma_sp_resolve.sv
module fma_sp_resolve
  import fma_sp_pkg::*;
#(
  parameter int W = FP_W
) (
  input  fp_class_e    cz,
  input  fp_class_e    cx,
  input  fp_class_e    cy,
  input  logic [W-1:0] z_val,
  input  logic         psign,
  input  logic         asign,
  input  logic [1:0]   rnd_mode,
  input  logic         nan_hit,
  input  logic         nan_sig,
  input  logic [W-1:0] nan_val,
  output byp_t         nxt
);
  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

  assign x_inf  = (cx == CL_INF);
  assign y_inf  = (cy == CL_INF);
  assign x_zero = (cx == CL_ZERO);
  assign y_zero = (cy == CL_ZERO);
  assign z_inf  = (cz == CL_INF);
  assign z_zero = (cz == CL_ZERO);

  always_comb begin
    nxt       = '0;
    nxt.psign = psign;
    nxt.asign = asign;
    if (nan_hit) begin
      nxt.valid = 1'b1;
      nxt.res   = nan_val;
      nxt.inv   = nan_sig;
    end else if ((x_inf && y_zero) || (x_zero && y_inf)) begin
      nxt.valid = 1'b1;
      nxt.res   = default_nan();
      nxt.inv   = 1'b1;
    end else if (x_inf || y_inf) begin
      nxt.valid = 1'b1;
      if (z_inf && (asign != psign)) begin
        nxt.res = default_nan();
        nxt.inv = 1'b1;
      end else begin
        nxt.res = make_inf(psign);
      end
    end else if (x_zero || y_zero) begin
      nxt.valid = 1'b1;
      if (z_inf)
        nxt.res = make_inf(asign);
      else if (z_zero)
        nxt.res = make_zero((asign == psign) ? asign : (rnd_mode == RM_DOWN));
      else
        nxt.res = {asign, z_val[W-2:0]};
    end else if (z_inf) begin
      nxt.valid = 1'b1;
      nxt.res   = make_inf(asign);
    end
  end
endmodule

// File: rtl/fma_special_front.sv
module fma_special_front
  import fma_sp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FP_W-1:0] op_z,
  input  logic [FP_W-1:0] op_x,
  input  logic [FP_W-1:0] op_y,
  input  logic            neg_prod,
  input  logic            neg_add,
  input  logic [1:0]      rnd_mode,
  output logic            byp_valid,
  output logic [FP_W-1:0] byp_result,
  output logic            byp_invalid,
  output logic            prod_sign,
  output logic            add_sign
);
  localparam int IDX_Z = 0;
  localparam int IDX_X = 1;
  localparam int IDX_Y = 2;

  logic [NOPS-1:0][FP_W-1:0] ops;
  fp_class_e                 cls [NOPS];
  logic                      nan_hit, nan_sig;
  logic [FP_W-1:0]           nan_val;
  logic                      ps_eff, as_eff;
  byp_t                      nxt, cur;

  assign ops[IDX_Z] = op_z;
  assign ops[IDX_X] = op_x;
  assign ops[IDX_Y] = op_y;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fma_sp_classify #(.EW(FP_EW), .MW(FP_MW)) u_cls (
      .operand (ops[i]),
      .cls     (cls[i])
    );
  end

  fma_sp_nan_pick #(.W(FP_W), .MW(FP_MW), .N(NOPS)) u_nan (
    .ops   (ops),
    .cls   (cls),
    .hit   (nan_hit),
    .sig   (nan_sig),
    .value (nan_val)
  );

  assign ps_eff = op_x[FP_W-1] ^ op_y[FP_W-1] ^ neg_prod;
  assign as_eff = op_z[FP_W-1] ^ neg_add;

  fma_sp_resolve #(.W(FP_W)) u_res (
    .cz       (cls[IDX_Z]),
    .cx       (cls[IDX_X]),
    .cy       (cls[IDX_Y]),
    .z_val    (op_z),
    .psign    (ps_eff),
    .asign    (as_eff),
    .rnd_mode (rnd_mode),
    .nan_hit  (nan_hit),
    .nan_sig  (nan_sig),
    .nan_val  (nan_val),
    .nxt      (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign byp_valid   = cur.valid;
  assign byp_result  = cur.res;
  assign byp_invalid = cur.inv;
  assign prod_sign   = cur.psign;
  assign add_sign    = cur.asign;
endmodule

// File: rtl/fma_special_front_chk.sv
module fma_special_front_chk
  import fma_sp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [FP_W-1:0] op_z,
  input logic [FP_W-1:0] op_x,
  input logic [FP_W-1:0] op_y,
  input logic            neg_prod,
  input logic            neg_add,
  input logic [1:0]      rnd_mode,
  input logic            byp_valid,
  input logic [FP_W-1:0] byp_result,
  input logic            byp_invalid,
  input logic            prod_sign,
  input logic            add_sign
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  function automatic logic is_zero(input logic [FP_W-1:0] v);
    return v[FP_W-2:0] == '0;
  endfunction
  function automatic logic is_norm(input logic [FP_W-1:0] v);
    return (v[FP_W-2:FP_MW] != '0) && (v[FP_W-2:FP_MW] != {FP_EW{1'b1}});
  endfunction
  function automatic logic is_snan(input logic [FP_W-1:0] v);
    return (v[FP_W-2:FP_MW] == {FP_EW{1'b1}}) && !v[FP_MW-1] && (v[FP_MW-2:0] != '0);
  endfunction

  assert_inv_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byp_invalid |-> byp_valid);

  assert_prod_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> prod_sign == $past(op_x[FP_W-1] ^ op_y[FP_W-1] ^ neg_prod));

  assert_add_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> add_sign == $past(op_z[FP_W-1] ^ neg_add));

  assert_snan_z_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(is_snan(op_z))) |->
      (byp_invalid && byp_result == ($past(op_z) | (FP_W'(1) << (FP_MW - 1)))));

  assert_zero_sum_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(is_zero(op_z) && is_zero(op_x) && is_zero(op_y) &&
      ((op_z[FP_W-1] ^ neg_add) != (op_x[FP_W-1] ^ op_y[FP_W-1] ^ neg_prod)))) |->
      (byp_valid && byp_result == {$past(rnd_mode) == RM_DOWN, {(FP_W-1){1'b0}}}));

  assert_normal_to_datapath_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(is_norm(op_z) && is_norm(op_x) && is_norm(op_y))) |-> !byp_valid);
endmodule

bind fma_special_front fma_special_front_chk u_chk (.*);

// File: tb/test_fma_special_front.sv
module test_fma_special_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_z, op_x, op_y;
  logic        neg_prod, neg_add;
  logic [1:0]  rnd_mode;
  logic        byp_valid, byp_invalid, prod_sign, add_sign;
  logic [63:0] byp_result;

  typedef struct {
    logic        v;
    logic [63:0] r;
    logic        inv;
    logic        ps;
    logic        as_;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   run_done = 0;

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SUB  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] QN1  = 64'h7FF8_0000_0000_1234;
  localparam logic [63:0] QN2  = 64'hFFF8_0000_0000_00AA;
  localparam logic [63:0] SN1  = 64'h7FF0_0000_0000_0055;
  localparam logic [63:0] SN2  = 64'hFFF0_0000_0000_0077;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

  always #5 clk = ~clk;

  fma_special_front i_fma_special_front (.*);

  function automatic bit f_inf(logic [63:0] v);  return v[62:0] == 63'h7FF0_0000_0000_0000; endfunction
  function automatic bit f_zero(logic [63:0] v); return v[62:0] == 63'h0; endfunction
  function automatic bit f_nan(logic [63:0] v);  return v[62:52] == 11'h7FF && v[51:0] != 0; endfunction
  function automatic bit f_sn(logic [63:0] v);   return f_nan(v) && !v[51]; endfunction

  function automatic exp_t model(logic [63:0] z, logic [63:0] x, logic [63:0] y,
                                 logic np, logic na, logic [1:0] rm, string tag);
    exp_t e;
    e.tag = tag; e.v = 1'b1; e.inv = 1'b0; e.r = 64'h0;
    e.ps = x[63] ^ y[63] ^ np;
    e.as_ = z[63] ^ na;
    if (f_sn(z))       begin e.r = z | 64'h0008_0000_0000_0000; e.inv = 1; end
    else if (f_sn(x))  begin e.r = x | 64'h0008_0000_0000_0000; e.inv = 1; end
    else if (f_sn(y))  begin e.r = y | 64'h0008_0000_0000_0000; e.inv = 1; end
    else if (f_nan(z)) e.r = z;
    else if (f_nan(x)) e.r = x;
    else if (f_nan(y)) e.r = y;
    else if ((f_inf(x) && f_zero(y)) || (f_zero(x) && f_inf(y))) begin e.r = DNAN; e.inv = 1; end
    else if (f_inf(x) || f_inf(y)) begin
      if (f_inf(z) && e.as_ != e.ps) begin e.r = DNAN; e.inv = 1; end
      else e.r = {e.ps, 63'h7FF0_0000_0000_0000};
    end
    else if (f_zero(x) || f_zero(y)) begin
      if (f_inf(z)) e.r = {e.as_, 63'h7FF0_0000_0000_0000};
      else if (f_zero(z)) e.r = {(e.as_ == e.ps) ? e.as_ : (rm == 2'b11), 63'h0};
      else e.r = {e.as_, z[62:0]};
    end
    else if (f_inf(z)) e.r = {e.as_, 63'h7FF0_0000_0000_0000};
    else e.v = 1'b0;
    return e;
  endfunction

  task automatic drive(logic [63:0] z, logic [63:0] x, logic [63:0] y,
                       logic np, logic na, logic [1:0] rm, string tag);
    @(negedge clk);
    op_z = z; op_x = x; op_y = y; neg_prod = np; neg_add = na; rnd_mode = rm;
    exp_q.push_back(model(z, x, y, np, na, rm, tag));
  endtask

  // monitor: one expected item per cycle after the capturing edge
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (byp_valid !== e.v || byp_invalid !== e.inv || prod_sign !== e.ps ||
          add_sign !== e.as_ || (e.v && byp_result !== e.r)) begin
        n_bad++;
        $display("FAIL %s: got v=%0b r=%h inv=%0b ps=%0b as=%0b exp v=%0b r=%h inv=%0b ps=%0b as=%0b",
                 e.tag, byp_valid, byp_result, byp_invalid, prod_sign, add_sign,
                 e.v, e.r, e.inv, e.ps, e.as_);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    op_z = 64'h0; op_x = 64'h0; op_y = 64'h0;
    neg_prod = 0; neg_add = 0; rnd_mode = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;
    if (byp_valid !== 0 || byp_result !== 0 || byp_invalid !== 0 || prod_sign !== 0 || add_sign !== 0) begin
      n_bad++;
      $display("FAIL R11: reset outputs v=%0b r=%h inv=%0b ps=%0b as=%0b expected all 0",
               byp_valid, byp_result, byp_invalid, prod_sign, add_sign);
    end
    @(negedge clk);
    rst_n = 1'b1;

    drive(ONE,  ONE,  NTWO, 0, 0, 2'b00, "R1 normal operands");
    drive(SUB,  NTWO, SUB,  0, 0, 2'b00, "R1 subnormal operands");
    drive(NTWO, ONE,  ONE,  1, 1, 2'b00, "R2 both flips");
    drive(ONE,  NTWO, ONE,  0, 1, 2'b00, "R2 addend flip");
    drive(SN1,  SN2,  QN1,  0, 0, 2'b00, "R3 snan z first");
    drive(QN1,  SN2,  SN1,  0, 0, 2'b00, "R3 snan x beats qnan z");
    drive(ONE,  QN2,  SN1,  0, 0, 2'b00, "R3 snan y beats qnan x");
    drive(QN2,  QN1,  ONE,  0, 0, 2'b00, "R4 qnan z first");
    drive(ONE,  ONE,  QN1,  1, 1, 2'b00, "R4 qnan y unchanged");
    drive(PINF, QN2,  PZ,   0, 0, 2'b00, "R4 qnan x over inf");
    drive(ONE,  PINF, PZ,   0, 0, 2'b00, "R5 inf times zero");
    drive(NINF, NZ,   NINF, 0, 0, 2'b00, "R5 zero times inf");
    drive(NINF, PINF, ONE,  0, 0, 2'b00, "R6 opposite infinities");
    drive(PINF, PINF, ONE,  0, 1, 2'b00, "R6 opposite via addend flip");
    drive(PINF, PINF, ONE,  0, 0, 2'b00, "R6 same infinities");
    drive(ONE,  NTWO, PINF, 0, 0, 2'b00, "R6 inf product finite z");
    drive(NINF, PZ,   ONE,  0, 0, 2'b00, "R7 zero product inf z");
    drive(NINF, PZ,   ONE,  1, 1, 2'b00, "R7 zero product flipped inf z");
    drive(NZ,   NZ,   PZ,   0, 0, 2'b00, "R8 same sign zeros");
    drive(PZ,   NZ,   ONE,  0, 0, 2'b00, "R8 mixed zeros nearest");
    drive(PZ,   NZ,   ONE,  0, 0, 2'b01, "R8 mixed zeros toward zero");
    drive(PZ,   NZ,   ONE,  0, 0, 2'b10, "R8 mixed zeros toward plus");
    drive(PZ,   NZ,   ONE,  0, 0, 2'b11, "R8 mixed zeros toward minus");
    drive(PZ,   PZ,   PZ,   0, 1, 2'b11, "R8 addend flip toward minus");
    drive(NTWO, PZ,   ONE,  0, 0, 2'b00, "R9 zero product normal z");
    drive(SUB,  ONE,  NZ,   0, 1, 2'b00, "R9 zero product subnormal z flipped");
    drive(NINF, ONE,  ONE,  0, 0, 2'b00, "R10 finite product inf z");
    drive(PINF, SUB,  NTWO, 1, 1, 2'b00, "R10 subnormal product inf z");
    drive(PZ,   SUB,  NINF, 0, 0, 2'b00, "R12 subnormal times inf");
    drive(NINF, PINF, SUB,  1, 0, 2'b00, "R12 inf times subnormal with inf z");
    drive(ONE,  ONE,  ONE,  0, 0, 2'b00, "R11 back to datapath after bypass");
    repeat (4) @(posedge clk);
    run_done = 1;
    #1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!run_done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule